// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block walks a circular table of receive buffer descriptors held in system memory. Each descriptor gives the base address of one receive buffer and its size in 16-bit words. When a fetch is requested, the block reads the next descriptor over a simple request/acknowledge memory read port. It then loads the current buffer address and the remaining word count, and advances its read pointer around the ring.

The ring is bounded by a start pointer and an end pointer. A write pointer marks the first descriptor that software has not yet handed over. When the read pointer catches up with the write pointer, the block raises an exhaustion flag, and the receive path must refuse packets while that flag is set. After each packet is stored, the receive path reports the packet's byte count. The block deducts the words used and, once the buffer runs low, marks the packet as the last one for that buffer and fetches the next descriptor by itself.

A narrow data mode (16-bit words) and a wide mode (32-bit words, with only the low half carrying data) select the memory stride.

Top module: `rrf_ring_fetcher`

## Requirements
- R1: After reset, busy, mem_req, exhausted and last_pkt are 0, and rd_ptr, buf_addr and words_left are all zero.
- R2: A fetch issues exactly four reads, one at a time. Read i (0..3) goes to address {seg_hi, rd_ptr + 2*i} in narrow mode or {seg_hi, rd_ptr + 4*i} in wide mode. mem_req and mem_addr hold steady until mem_ack is seen.
- R3: The four words read are, in order: buffer address low, buffer address high, word count low, word count high. Only bits [15:0] of mem_rdata are used. At the clock edge of the fourth acknowledge, buf_addr becomes {word1, word0} and words_left becomes {word3, word2}.
- R4: At the fourth acknowledge, rd_ptr advances by 8 in narrow mode or by 16 in wide mode, with 16-bit wraparound.
- R5: If the advanced pointer equals ring_end, rd_ptr is set to ring_start instead.
- R6: If the new rd_ptr equals wr_ptr, exhausted is set and stays set until a cycle with exh_clear high. That cycle clears it and requests a new fetch. exh_clear while exhausted is 0 has no effect.
- R7: busy rises the cycle after a fetch request and falls the cycle after the fourth acknowledge, unless another fetch is pending.
- R8: A fetch request that arrives while a fetch is in progress is held. The next fetch starts after the current one ends, using the updated rd_ptr.
- R9: On pkt_done, words_left drops by (pkt_bytes + 4) / 2, rounded down. last_pkt is set to 1 if the result is below EOB_COUNT (default 0x2F8) and to 0 otherwise. When it is set, a new fetch is requested at once.
- R10: ptr_load writes ptr_value into rd_ptr when the block is idle. A ptr_load while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: 32-bit data words, 0: 16-bit |
| seg_hi | input | 16 | Upper address segment for descriptor reads |
| ring_start | input | 16 | First descriptor offset of the ring |
| ring_end | input | 16 | Offset one past the last descriptor |
| wr_ptr | input | 16 | Offset of first descriptor not yet supplied |
| ptr_load | input | 1 | Load rd_ptr from ptr_value |
| ptr_value | input | 16 | Value for ptr_load |
| fetch_req | input | 1 | Request a descriptor fetch |
| exh_clear | input | 1 | Clear exhaustion and refetch |
| pkt_done | input | 1 | A packet has been stored |
| pkt_bytes | input | 16 | Byte count of that packet, without FCS |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read acknowledge with data |
| mem_rdata | input | 32 | Read data |
| rd_ptr | output | 16 | Ring read pointer |
| buf_addr | output | 32 | Current buffer address |
| words_left | output | 32 | Remaining buffer word count |
| busy | output | 1 | Fetch pending or in progress |
| exhausted | output | 1 | Ring exhausted, refuse reception |
| last_pkt | output | 1 | Last packet fits in current buffer |

## Verification
The assertions rely on three conditions on the inputs:
- mem_ack is raised only while mem_req is high.
- pkt_done never coincides with the fourth acknowledge of a fetch.
- ring_start, ring_end and wr_ptr stay constant while a fetch runs.

The stimulus respects all three. Acknowledges are driven one cycle at a time, only after a request has been seen. Packets are reported only once busy is low. Ring settings change only between fetches.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int PTR_W      = 16;
  localparam int HALF_W     = 16;
  localparam int CNT_W      = 2 * HALF_W;
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // byte offset of descriptor word idx from the descriptor start
  function automatic ptr_t word_offset(input logic [IDX_W-1:0] idx, input logic wide);
    return wide ? ptr_t'({idx, 2'b00}) : ptr_t'({idx, 1'b0});
  endfunction

  // next read pointer: one descriptor further, back to first at the end mark
  function automatic ptr_t ring_step(input ptr_t rd, input logic wide,
                                     input ptr_t first, input ptr_t last);
    ptr_t nxt;
    nxt = rd + (wide ? ptr_t'(DESC_WORDS * 4) : ptr_t'(DESC_WORDS * 2));
    return (nxt == last) ? first : nxt;
  endfunction

  // word count left after storing a packet and its 4-byte check sequence
  function automatic cnt_t consume_words(input cnt_t left, input logic [15:0] bytes);
    cnt_t used;
    used = (cnt_t'(bytes) + cnt_t'(4)) >> 1;
    return left - used;
  endfunction
endpackage

// File: rtl/rrf_mem_seq.sv
module rrf_mem_seq
  import rrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEG_W  = 16,
  localparam int ADDR_W = SEG_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide,
  input  logic [SEG_W-1:0]  seg,
  input  ptr_t              rd_ptr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              active,
  output logic              done,
  output cnt_t              base,
  output cnt_t              count
);
  logic [IDX_W-1:0]  idx;
  logic [HALF_W-1:0] cap [DESC_WORDS-1];
  logic [HALF_W-1:0] rd_lo;
  logic              unused_hi;

  assign rd_lo     = mem_rdata[HALF_W-1:0];
  assign unused_hi = ^mem_rdata[DATA_W-1:HALF_W];
  assign mem_req   = active;
  assign mem_addr  = {seg, rd_ptr + word_offset(idx, wide)};
  assign done      = active && mem_ack && (idx == IDX_W'(DESC_WORDS - 1));
  assign base      = {cap[1], cap[0]};
  assign count     = {rd_lo, cap[2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active && mem_ack) begin
      idx <= idx + 1'b1;
      if (done) active <= 1'b0;
    end
  end

  for (genvar g = 0; g < DESC_WORDS - 1; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rst_n) cap[g] <= '0;
      else if (active && mem_ack && idx == IDX_W'(g)) cap[g] <= rd_lo;
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
endmodule

// File: rtl/rrf_ring_ptr.sv
module rrf_ring_ptr
  import rrf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wide,
  input  ptr_t first,
  input  ptr_t last,
  input  ptr_t wr_ptr,
  input  logic load,
  input  ptr_t load_val,
  input  logic adv,
  input  logic exh_clr,
  output ptr_t rd_ptr,
  output logic exhausted,
  output logic exh_cleared
);
  ptr_t nxt;
  assign nxt         = ring_step(rd_ptr, wide, first, last);
  assign exh_cleared = exh_clr && exhausted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      exhausted <= 1'b0;
    end else begin
      if (adv) rd_ptr <= nxt;
      else if (load) rd_ptr <= load_val;
      if (adv && nxt == wr_ptr) exhausted <= 1'b1;
      else if (exh_clr) exhausted <= 1'b0;
    end
  end

  // R6
  exh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted && !exh_clr |=> exhausted);
endmodule

// File: rtl/rrf_word_track.sv
module rrf_word_track
  import rrf_pkg::*;
#(
  parameter cnt_t EOB_COUNT = 32'h0000_02F8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  cnt_t        load_cnt,
  input  logic        pkt_done,
  input  logic [15:0] pkt_bytes,
  output cnt_t        words_left,
  output logic        last_pkt,
  output logic        low_water
);
  cnt_t after;
  assign after     = consume_words(words_left, pkt_bytes);
  assign low_water = pkt_done && !load && (after < EOB_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_left <= '0;
      last_pkt   <= 1'b0;
    end else if (load) begin
      words_left <= load_cnt;
    end else if (pkt_done) begin
      words_left <= after;
      last_pkt   <= (after < EOB_COUNT);
    end
  end

  // R9
  last_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && !load |=> last_pkt == (words_left < EOB_COUNT));
endmodule

// File: rtl/rrf_ring_fetcher.sv
module rrf_ring_fetcher
  import rrf_pkg::*;
#(
  parameter int   DATA_W    = 32,
  parameter int   SEG_W     = 16,
  parameter cnt_t EOB_COUNT = 32'h0000_02F8,
  localparam int  ADDR_W    = SEG_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic [SEG_W-1:0]  seg_hi,
  input  logic [PTR_W-1:0]  ring_start,
  input  logic [PTR_W-1:0]  ring_end,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_value,
  input  logic              fetch_req,
  input  logic              exh_clear,
  input  logic              pkt_done,
  input  logic [15:0]       pkt_bytes,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [CNT_W-1:0]  buf_addr,
  output logic [CNT_W-1:0]  words_left,
  output logic              busy,
  output logic              exhausted,
  output logic              last_pkt
);
  logic pend, active, start, fetch_done, exh_cleared, low_water, trig;
  cnt_t base, count;

  assign trig  = fetch_req || exh_cleared || low_water;
  assign start = pend && !active;
  assign busy  = pend || active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      buf_addr <= '0;
    end else begin
      if (trig) pend <= 1'b1;
      else if (start) pend <= 1'b0;
      if (fetch_done) buf_addr <= base;
    end
  end

  rrf_mem_seq #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide_mode), .seg(seg_hi),
    .rd_ptr(rd_ptr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .active(active),
    .done(fetch_done), .base(base), .count(count));

  rrf_ring_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .wide(wide_mode), .first(ring_start),
    .last(ring_end), .wr_ptr(wr_ptr), .load(ptr_load && !busy),
    .load_val(ptr_value), .adv(fetch_done), .exh_clr(exh_clear),
    .rd_ptr(rd_ptr), .exhausted(exhausted), .exh_cleared(exh_cleared));

  rrf_word_track #(.EOB_COUNT(EOB_COUNT)) u_track (
    .clk(clk), .rst_n(rst_n), .load(fetch_done), .load_cnt(count),
    .pkt_done(pkt_done), .pkt_bytes(pkt_bytes), .words_left(words_left),
    .last_pkt(last_pkt), .low_water(low_water));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(fetch_done));

  // R8
  held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done && pend |=> ##1 mem_req);
endmodule

// File: tb/rrf_ring_fetcher_tb.sv
module rrf_ring_fetcher_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, wide_mode, ptr_load, fetch_req, exh_clear, pkt_done, mem_ack;
  logic [15:0] seg_hi, ring_start, ring_end, wr_ptr, ptr_value, pkt_bytes, rd_ptr;
  logic [31:0] mem_addr, mem_rdata, buf_addr, words_left;
  logic        mem_req, busy, exhausted, last_pkt;

  int checks = 0, errors = 0;
  bit finished = 0;

  rrf_ring_fetcher u_dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .seg_hi(seg_hi),
    .ring_start(ring_start), .ring_end(ring_end), .wr_ptr(wr_ptr),
    .ptr_load(ptr_load), .ptr_value(ptr_value), .fetch_req(fetch_req),
    .exh_clear(exh_clear), .pkt_done(pkt_done), .pkt_bytes(pkt_bytes),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .rd_ptr(rd_ptr), .buf_addr(buf_addr),
    .words_left(words_left), .busy(busy), .exhausted(exhausted),
    .last_pkt(last_pkt));

  // {wide, seg, rd, start, end, wr, expected rd after fetch}
  localparam logic [96:0] VEC [5] = '{
    {1'b0, 16'hA000, 16'h0100, 16'h0100, 16'h0140, 16'h0120, 16'h0108},
    {1'b1, 16'hA001, 16'h0200, 16'h0200, 16'h0300, 16'h0250, 16'h0210},
    {1'b0, 16'hB000, 16'h0138, 16'h0100, 16'h0140, 16'h0120, 16'h0100},
    {1'b1, 16'hB001, 16'h02F0, 16'h0200, 16'h0300, 16'h0250, 16'h0200},
    {1'b0, 16'hC000, 16'hFFF8, 16'h4000, 16'h8000, 16'h1000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_fetch();
    fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  task automatic load_ptr(input logic [15:0] v);
    ptr_load = 1'b1; ptr_value = v;
    @(negedge clk);
    ptr_load = 1'b0;
  endtask

  // serve one four-word descriptor read, checking each address (R2)
  task automatic serve(input logic [15:0] rd, input logic [63:0] dd);
    for (int i = 0; i < 4; i++) begin
      int t = 0;
      logic [31:0] ea;
      while (!mem_req && t < 50) begin @(negedge clk); t++; end
      ea = {seg_hi, rd + 16'(wide_mode ? 4 * i : 2 * i)};
      chk("R2 addr", mem_addr, ea);
      if (i == 1) begin
        @(negedge clk);
        chk("R2 held", {mem_req, mem_addr}, {1'b1, ea});
      end
      mem_ack = 1'b1;
      mem_rdata = {16'hDEAD ^ 16'(i), dd[16*i +: 16]};
      @(negedge clk);
      mem_ack = 1'b0;
      mem_rdata = '0;
    end
  endtask

  task automatic pkt(input logic [15:0] b);
    pkt_done = 1'b1; pkt_bytes = b;
    @(negedge clk);
    pkt_done = 1'b0;
  endtask

  initial begin
    rst_n = 0; wide_mode = 0; ptr_load = 0; fetch_req = 0; exh_clear = 0;
    pkt_done = 0; mem_ack = 0; seg_hi = 0; ring_start = 0; ring_end = 0;
    wr_ptr = 0; ptr_value = 0; pkt_bytes = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 req", mem_req, 0);
    chk("R1 exh", exhausted, 0);
    chk("R1 last", last_pkt, 0);
    chk("R1 rd", rd_ptr, 0);
    chk("R1 base", buf_addr, 0);
    chk("R1 words", words_left, 0);

    for (int k = 0; k < 5; k++) begin
      logic [63:0] dd;
      wide_mode = VEC[k][96]; seg_hi = VEC[k][95:80];
      ring_start = VEC[k][63:48]; ring_end = VEC[k][47:32]; wr_ptr = VEC[k][31:16];
      load_ptr(VEC[k][79:64]);
      chk("R10 load", rd_ptr, VEC[k][79:64]);
      dd = {16'h4000 + 16'(k), 16'h3000 + 16'(k), 16'h2000 + 16'(k), 16'h1000 + 16'(k)};
      pulse_fetch();
      chk("R7 busy up", busy, 1);
      serve(VEC[k][79:64], dd);
      chk("R4 R5 rd", rd_ptr, VEC[k][15:0]);
      chk("R3 base", buf_addr, {16'h2000 + 16'(k), 16'h1000 + 16'(k)});
      chk("R3 count", words_left, {16'h4000 + 16'(k), 16'h3000 + 16'(k)});
      chk("R7 busy down", busy, 0);
      chk("R6 no exh", exhausted, 0);
    end

    // R6: exhaustion, hold, clear with refetch
    wide_mode = 0; seg_hi = 16'hA000; ring_start = 16'h0100;
    ring_end = 16'h0140; wr_ptr = 16'h0120;
    load_ptr(16'h0118);
    pulse_fetch();
    serve(16'h0118, 64'h0004_0003_0002_0001);
    chk("R6 set", exhausted, 1);
    chk("R6 rd", rd_ptr, 16'h0120);
    repeat (3) @(negedge clk);
    chk("R6 holds", exhausted, 1);
    exh_clear = 1; @(negedge clk); exh_clear = 0;
    chk("R6 cleared", exhausted, 0);
    chk("R6 refetch", busy, 1);
    serve(16'h0120, 64'h0008_0007_0006_0005);
    chk("R6 after refetch rd", rd_ptr, 16'h0128);
    chk("R6 after refetch exh", exhausted, 0);
    exh_clear = 1; @(negedge clk); exh_clear = 0;
    @(negedge clk);
    chk("R6 clear ignored", {busy, mem_req, exhausted}, 3'b000);

    // R8 held request, R10 load ignored while busy
    pulse_fetch();
    while (!mem_req) @(negedge clk);
    fetch_req = 1; ptr_load = 1; ptr_value = 16'h7777;
    @(negedge clk);
    fetch_req = 0; ptr_load = 0;
    serve(16'h0128, 64'h1111_2222_3333_4444);
    chk("R8 still busy", busy, 1);
    chk("R10 load ignored", rd_ptr, 16'h0130);
    serve(16'h0130, 64'h0000_0400_5678_9ABC);
    chk("R8 second rd", rd_ptr, 16'h0138);
    chk("R8 second base", buf_addr, 32'h5678_9ABC);
    chk("R8 idle", busy, 0);

    // R9 word consumption and low-water refetch (count 0x400)
    chk("R9 start", words_left, 32'h400);
    pkt(16'd61);
    chk("R9 odd", words_left, 32'd992);
    chk("R9 not last", {last_pkt, busy}, 2'b00);
    pkt(16'd400);
    chk("R9 second", words_left, 32'd790);
    chk("R9 still not last", {last_pkt, busy}, 2'b00);
    pkt(16'd60);
    chk("R9 low", words_left, 32'd758);
    chk("R9 last set", last_pkt, 1);
    chk("R9 auto fetch", busy, 1);
    serve(16'h0138, 64'h0000_0500_0000_0000);
    chk("R9 R5 wrap rd", rd_ptr, 16'h0100);
    chk("R9 reloaded", words_left, 32'h500);
    chk("R9 done", busy, 0);
    pkt(16'd100);
    chk("R9 last clears", last_pkt, 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule